// File: doc/BRIEF.md
# Masked Exclusive Prefix-Count Unit

This block turns a source bit mask into a vector of running counts. Each destination element receives the number of set source bits that sit at strictly lower positions and are enabled. It is an exclusive, cumulative population count, so element zero always receives zero. An optional enable mask restricts which positions are counted. The same mask also restricts which destination elements are written. When no enable mask is selected, every position is treated as enabled.

The operation is one-shot. On the clock edge where `start` is high, the unit samples its inputs and updates its result slots. In the following cycle it raises `done` for one cycle, together with the per-element write-enable vector and the error flag. Each result slot is 64 bits wide, and the count is right-aligned in it. The element width selects how many low bits of a written slot receive the count. The bits above that width keep their previous contents. A nonzero start index is an illegal request: it is reported through `illegal`, and no element is written.

Top module: `iota_mask_unit`

## Requirements
- R1: After reset, `done`, `illegal`, `wr_en` and every bit of `result` are zero.
- R2: `done` is high in exactly the cycle after a cycle in which `start` was sampled high, and low otherwise. `wr_en` and `illegal` are zero whenever `done` is low.
- R3: With `use_mask`=0, a written element i holds the number of set `src_mask` bits at positions below i. Element 0 holds zero.
- R4: With `use_mask`=1, source bits at positions where `en_mask` is 0 are not added to the count of any element.
- R5: With `use_mask`=1, an element whose `en_mask` bit is 0 is not written: its `wr_en` bit is 0 and its result slot keeps its previous value.
- R6: With `use_mask`=0, the value of `en_mask` has no effect, and every element below the vector length is written.
- R7: `ew_sel` encodes the element width as 0=8, 1=16, 2=32, 3=64 bits. A written slot takes the count zero-extended into its low element-width bits, and the slot bits above the element width are unchanged.
- R8: A request with nonzero `start_idx` sets `illegal` alongside `done`, writes no element (`wr_en` all zero), and leaves every result slot unchanged.
- R9: Elements at index `vl` or above are not written. A `vl` above MAXVL behaves as MAXVL, and `vl`=0 writes nothing.
- R10: When a count does not fit in the element width, only its least-significant element-width bits are stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; inputs are sampled on this edge |
| vl | input | $clog2(MAXVL+1) | Number of elements to process |
| start_idx | input | SIW | Start index; must be zero for a legal request |
| use_mask | input | 1 | 1 selects `en_mask`, 0 treats all positions as enabled |
| en_mask | input | MAXVL | Per-position enable |
| src_mask | input | MAXVL | Source bits to be counted |
| ew_sel | input | 2 | Element width code |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal-request flag, valid with `done` |
| wr_en | output | MAXVL | Elements written by the last request, valid with `done` |
| result | output | MAXVL*64 | Result slots, 64 bits per element, element i at bits [64i+63:64i] |

## Verification
The embedded assertions assume that `start` is never high while `rst_n` is low. They also assume that `vl`, `ew_sel` and the masks are stable and known on the edge where `start` is sampled. The bench drives every input only at falling edges and holds it there for the whole sampling edge. Random requests cover `vl` both below and above MAXVL and any `ew_sel` code. They include an occasional nonzero start index, and `start` is never asserted during reset. The bench instance uses a vector length large enough for counts to exceed 255, so that the 8-bit truncation and the preservation of the upper slot bits can be seen.

// File: rtl/iota_pkg.sv
// Package iota_pkg
// Shared types for the prefix-count unit: the element width code and the
// mask of slot bits that a given element width covers.
// Assumes a fixed 64-bit result slot per element.
package iota_pkg;

    localparam int SLOT_W = 64;

    typedef enum logic [1:0] {
        EW_8  = 2'd0,
        EW_16 = 2'd1,
        EW_32 = 2'd2,
        EW_64 = 2'd3
    } elem_width_e;

    // Low-bit mask of the slot bits owned by an element of width w
    function automatic logic [SLOT_W-1:0] width_keep(elem_width_e w);
        case (w)
            EW_8:    return 64'h0000_0000_0000_00FF;
            EW_16:   return 64'h0000_0000_0000_FFFF;
            EW_32:   return 64'h0000_0000_FFFF_FFFF;
            default: return 64'hFFFF_FFFF_FFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/iota_prefix_count.sv
// Module iota_prefix_count
// Combinational exclusive prefix population count over N contributing bits.
// Output lane i carries the number of set bits at positions below i.
// Assumes CW is wide enough to hold N, so no intermediate sum wraps.
module iota_prefix_count #(
    parameter int N  = 16,
    parameter int CW = 5
) (
    input  logic [N-1:0]    bits_i,
    output logic [N*CW-1:0] excl_o
);

    logic [CW-1:0] incl [N];

    // Inclusive running sum, a ripple chain along the lanes
    assign incl[0] = CW'(bits_i[0]);
    for (genvar gi = 1; gi < N; gi++) begin : g_incl
        assign incl[gi] = incl[gi-1] + CW'(bits_i[gi]);
    end

    // Exclusive count: the inclusive sum less the lane's own bit
    for (genvar gi = 0; gi < N; gi++) begin : g_excl
        assign excl_o[gi*CW +: CW] = incl[gi] - CW'(bits_i[gi]);
    end

endmodule

// File: rtl/iota_lane_merge.sv
// Module iota_lane_merge
// Fits one count into a 64-bit slot at the selected element width.
// The count is zero-extended, then cut to the element width. The slot
// bits above that width are carried over from the old slot value.
// Assumes CW <= 64.
module iota_lane_merge
    import iota_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic [SLOT_W-1:0] old_i,
    input  logic [CW-1:0]     cnt_i,
    input  elem_width_e       ew_i,
    output logic [SLOT_W-1:0] new_o
);

    logic [SLOT_W-1:0] keep;
    logic [SLOT_W-1:0] ext;

    // Widen the count and pick the owned bit range
    always_comb begin
        keep  = width_keep(ew_i);
        ext   = SLOT_W'(cnt_i);
        new_o = (old_i & ~keep) | (ext & keep);
    end

endmodule

// File: rtl/iota_mask_unit.sv
// Module iota_mask_unit (top)
// One-shot masked exclusive prefix count. On a sampled start it writes
// enabled in-range elements with their running count and holds the others.
// One cycle later it pulses done with the write-enable vector and the
// illegal flag. Assumes start is low while rst_n is low.
module iota_mask_unit
    import iota_pkg::*;
#(
    parameter int MAXVL = 16,
    parameter int SIW   = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [$clog2(MAXVL+1)-1:0]   vl,
    input  logic [SIW-1:0]               start_idx,
    input  logic                         use_mask,
    input  logic [MAXVL-1:0]             en_mask,
    input  logic [MAXVL-1:0]             src_mask,
    input  logic [1:0]                   ew_sel,
    output logic                         done,
    output logic                         illegal,
    output logic [MAXVL-1:0]             wr_en,
    output logic [MAXVL*SLOT_W-1:0]      result
);

    localparam int VLW = $clog2(MAXVL + 1);
    localparam int CW  = VLW;

    logic [VLW-1:0]      vl_eff;
    logic [MAXVL-1:0]    in_range;
    logic [MAXVL-1:0]    eff_en;
    logic [MAXVL-1:0]    contrib;
    logic [MAXVL-1:0]    lane_we;
    logic                legal;
    logic [MAXVL*CW-1:0] counts;
    elem_width_e         ew;

    // Clamp the length, resolve the enable mask, decide legality
    always_comb begin
        vl_eff  = (vl > VLW'(MAXVL)) ? VLW'(MAXVL) : vl;
        eff_en  = use_mask ? en_mask : '1;
        contrib = src_mask & eff_en;
        legal   = (start_idx == '0);
        lane_we = eff_en & in_range & {MAXVL{legal}};
        ew      = elem_width_e'(ew_sel);
    end

    for (genvar gr = 0; gr < MAXVL; gr++) begin : g_range
        assign in_range[gr] = (VLW'(gr) < vl_eff);
    end

    iota_prefix_count #(.N(MAXVL), .CW(CW)) u_prefix (
        .bits_i (contrib),
        .excl_o (counts)
    );

    // Completion pulse, error flag and write-enable report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done    <= 1'b0;
            illegal <= 1'b0;
            wr_en   <= '0;
        end else begin
            done    <= start;
            illegal <= start && !legal;
            wr_en   <= start ? lane_we : '0;
        end
    end

    for (genvar gl = 0; gl < MAXVL; gl++) begin : g_lane
        logic [SLOT_W-1:0] slot_q;
        logic [SLOT_W-1:0] slot_d;

        iota_lane_merge #(.CW(CW)) u_merge (
            .old_i (slot_q),
            .cnt_i (counts[gl*CW +: CW]),
            .ew_i  (ew),
            .new_o (slot_d)
        );

        // Result slot: update only when this lane is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (start && lane_we[gl])
                slot_q <= slot_d;
        end

        assign result[gl*SLOT_W +: SLOT_W] = slot_q;

        // R5
        slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (done && !wr_en[gl]) |-> (result[gl*SLOT_W +: SLOT_W] == $past(result[gl*SLOT_W +: SLOT_W])));
    end

    // R2
    done_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    // R2
    done_only_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!done && wr_en == '0 && !illegal));

    // R8
    illegal_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (wr_en == '0 && done));

    // R9
    beyond_vl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((wr_en >> $past(vl_eff)) == '0));

    // R3
    first_count_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        counts[CW-1:0] == '0);

endmodule

// File: tb/iota_mask_unit_test.sv
`timescale 1ns/1ps
module iota_mask_unit_test;

    localparam int N   = 272;
    localparam int VLW = $clog2(N + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [VLW-1:0]       vl = '0;
    logic [7:0]           start_idx = '0;
    logic                 use_mask = 1'b0;
    logic [N-1:0]         en_mask = '0;
    logic [N-1:0]         src_mask = '0;
    logic [1:0]           ew_sel = '0;
    logic                 done;
    logic                 illegal;
    logic [N-1:0]         wr_en;
    logic [N*64-1:0]      result;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit finished = 0;
    logic [63:0] mdl [N];

    iota_mask_unit #(.MAXVL(N), .SIW(8)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
        .start_idx(start_idx), .use_mask(use_mask), .en_mask(en_mask),
        .src_mask(src_mask), .ew_sel(ew_sel), .done(done),
        .illegal(illegal), .wr_en(wr_en), .result(result)
    );

    always #10 clk = ~clk;

    task automatic check(input string tag, input bit ok, input string detail);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s", tag, detail);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check("WATCHDOG", 1'b0, "run did not end");
            finish_run();
        end
    end

    function automatic logic [63:0] keep_of(input logic [1:0] ew);
        if (ew == 2'd3) return '1;
        return (64'd1 << (8 << ew)) - 64'd1;
    endfunction

    task automatic compare_slots(input string tag);
        bit ok = 1;
        string d = "all slots match";
        for (int i = 0; i < N; i++) begin
            if (ok && result[i*64 +: 64] !== mdl[i]) begin
                ok = 0;
                d = $sformatf("slot %0d actual=%h expected=%h", i, result[i*64 +: 64], mdl[i]);
            end
        end
        check(tag, ok, d);
    endtask

    task automatic op(input string tag, input logic [N-1:0] s, input logic [N-1:0] e,
                      input logic um, input logic [1:0] ew, input int vlv, input int sidx);
        logic [N-1:0] exp_we = '0;
        logic [63:0] keep = keep_of(ew);
        int run = 0;
        int vle = (vlv > N) ? N : vlv;
        @(negedge clk);
        src_mask = s; en_mask = e; use_mask = um; ew_sel = ew;
        vl = VLW'(vlv); start_idx = 8'(sidx); start = 1'b1;
        for (int i = 0; i < N; i++) begin
            bit en_i = um ? e[i] : 1'b1;
            if (en_i && i < vle && sidx == 0) begin
                exp_we[i] = 1'b1;
                mdl[i] = (mdl[i] & ~keep) | (64'(run) & keep);
            end
            if (en_i && s[i]) run++;
        end
        @(negedge clk);
        start = 1'b0;
        check("R2", done === 1'b1, $sformatf("done actual=%b expected=1", done));
        check(sidx != 0 ? "R8" : tag, illegal === (sidx != 0),
              $sformatf("illegal actual=%b expected=%b", illegal, sidx != 0));
        check(tag, wr_en === exp_we, $sformatf("wr_en actual=%h expected=%h", wr_en, exp_we));
        compare_slots(tag);
        @(negedge clk);
        check("R2", done === 1'b0 && wr_en === '0,
              $sformatf("done actual=%b wr_en=%h expected 0", done, wr_en));
    endtask

    function automatic logic [N-1:0] rnd_bits();
        logic [N-1:0] v;
        for (int k = 0; k < N; k++) v[k] = 1'($urandom_range(0, 1));
        return v;
    endfunction

    initial begin
        logic [N-1:0] alt;
        void'($urandom(32'd7341));
        for (int i = 0; i < N; i++) mdl[i] = '0;
        for (int i = 0; i < N; i++) alt[i] = (i % 2 == 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", done === 1'b0 && illegal === 1'b0 && wr_en === '0,
              $sformatf("done=%b illegal=%b wr_en=%h expected zeros", done, illegal, wr_en));
        compare_slots("R1");

        // R3 unmasked exclusive count
        op("R3", alt, '0, 1'b0, 2'd3, N, 0);
        // R6 enable mask ignored when not selected
        op("R6", rnd_bits(), '0, 1'b0, 2'd2, N, 0);
        // R4 disabled source bits not counted
        op("R4", '1, rnd_bits(), 1'b1, 2'd3, N, 0);
        // R5 disabled lanes keep prior contents
        op("R5", alt, alt, 1'b1, 2'd3, N, 0);
        // R9 length limits: short, zero, above maximum
        op("R9", '1, '0, 1'b0, 2'd3, 5, 0);
        op("R9", rnd_bits(), '0, 1'b0, 2'd3, 0, 0);
        op("R9", rnd_bits(), '0, 1'b0, 2'd1, 400, 0);
        // R8 nonzero start index
        op("R8", '1, '1, 1'b0, 2'd3, N, 3);
        // R10 counts above 255 cut to 8 bits
        op("R10", '1, '0, 1'b0, 2'd0, N, 0);
        // R7 16-bit write leaves bit 8 set, then 8-bit write keeps it
        op("R7", '1, '0, 1'b0, 2'd1, N, 0);
        op("R7", '0, '0, 1'b0, 2'd0, N, 0);

        // Random mix
        for (int t = 0; t < 40; t++) begin
            int sidx = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 255)) : 0;
            op("R4", rnd_bits(), rnd_bits(), 1'($urandom_range(0, 1)),
               2'($urandom_range(0, 3)), int'($urandom_range(0, 300)), sidx);
        end
        finish_run();
    end

endmodule